// File: doc/BRIEF.md
# Averaging Successive-Approximation Converter Sequencer

This block runs a 10-bit successive-approximation auxiliary converter. A host writes one control word. If that word has its start bit set while the block is idle, the block does four things. It latches the word's settings. It forms a slow conversion clock from the system clock as a one-cycle enable pulse, dividing by a programmable power of two. It then performs a programmable number of back-to-back conversions. For each conversion it drives a trial code to the external DAC and reads back an external comparator.

The conversion results are summed and divided by the conversion count to give one averaged result. The result is held on a parallel output. If the control word asked for it, the result is also sent out serially.

Three selects go to the analog side: the input-source select, the reference select and a sample strobe. The selects are held constant for the whole sequence. The comparator, DAC, multiplexer and reference are not part of this block.

Top module: `aux_sar_seq`

## Requirements
- R1: After reset, `busy`, `result`, `result_valid`, `dac_code`, `hold_smp`, `ref_sel_o`, `src_sel_o`, `ser_out` and `ser_valid` are all 0.
- R2: The control word is laid out as follows: bit 0 is start, bits 2:1 are source, bit 3 is reference, bits 6:4 are the averaging code, bits 9:7 are the divider code and bit 10 is serial enable. A write with start = 1 while idle raises `busy` at the next edge. `busy` clears by itself after exactly 12·N·D system cycles, where N is the conversion count and D is the divisor.
- R3: While `busy` is high, a write has no effect on the running sequence, whether it sets start or clears it. This covers the sequence's length, its result and its selects, and the write does not start a new sequence afterwards.
- R4: Each conversion takes 12 conversion-clock ticks. Tick 1 pulses `hold_smp` and sets `dac_code` to 0x200. The next ten ticks decide the bits from MSB to LSB, keeping the trial bit when `cmp_in` is 1. The twelfth tick loads the result. With `cmp_in` = (input ≥ `dac_code`), a conversion yields min(input, 1023).
- R5: Averaging codes 0 to 5 select N = 1, 2, 4, 8, 16 and 32 conversions. Codes 6 and 7 also select 32. `result` is the sum of the N conversion codes shifted right by log2 N.
- R6: Divider code k divides the system clock by 2^k (codes 0 to 7 give ÷1 to ÷128). The conversion clock is an enable pulse, and the sequence length follows R2.
- R7: `ref_sel_o` and `src_sel_o` take the start word's values at the start edge. They stay unchanged until the next accepted start.
- R8: If serial enable was set in the start word, `ser_valid` is high for the 10 cycles after completion. During those cycles `ser_out` shows the result MSB first, one bit per system cycle. If it was clear, `ser_out` and `ser_valid` stay 0.
- R9: `result_valid` pulses for exactly one cycle, in the cycle in which `busy` has just fallen. `result` holds its value until the next completion.
- R10: `hold_smp` pulses exactly N times per sequence and only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 11 | Control word (layout in R2) |
| cmp_in | input | 1 | Comparator decision, 1 when input ≥ DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| hold_smp | output | 1 | Sample strobe for the track/hold |
| ref_sel_o | output | 1 | Latched reference select |
| src_sel_o | output | 2 | Latched input source select |
| busy | output | 1 | Sequence running (self-clearing start bit) |
| result | output | 10 | Averaged result |
| result_valid | output | 1 | One-cycle completion pulse |
| ser_out | output | 1 | Serial result bit |
| ser_valid | output | 1 | Serial bit valid |

## Verification
The hardest situation to reach from the ports is a long averaged sequence in which every conversion sees a different input. Reaching it needs the comparator to change its input exactly when each new sample is taken. The bench's comparator model therefore moves to the next entry of a random input table on every `hold_smp` pulse. This makes a dropped, extra or misordered conversion change the average.

Writes in the middle of a sequence, both setting and clearing start and carrying altered fields, are mixed into directed runs. These runs check that the sequence length, the result and the selects do not move.

// File: rtl/aux_sar_pkg.sv
package aux_sar_pkg;

  // number of right shifts applied to the sum for an averaging code
  function automatic int avg_log2(input logic [2:0] code, input int max_log2);
    return (int'(code) > max_log2) ? max_log2 : int'(code);
  endfunction

  // terminal count of the enable divider for a divider code
  function automatic int div_limit(input int code);
    return (1 << code) - 1;
  endfunction

  // conversions minus one for a shift amount
  function automatic int conv_last(input int sh);
    return (1 << sh) - 1;
  endfunction

endpackage

// File: rtl/aux_ce_div.sv
module aux_ce_div #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aux_sar_core.sv
module aux_sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             smp_pulse,
  output logic             load_pulse
);
  localparam int STEPS  = RES_W + 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam int LAST   = STEPS - 1;

  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  code;
  logic              bit_step;
  int                bidx;

  assign smp_pulse  = run && tick && (step == '0);
  assign load_pulse = run && tick && (step == STEP_W'(LAST));
  assign bit_step   = run && tick && (step != '0) && (step != STEP_W'(LAST));
  assign dac_code   = code;

  always_comb begin
    bidx = RES_W - int'(step);
    if (bidx < 0)      bidx = 0;
    if (bidx >= RES_W) bidx = RES_W - 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 step <= '0;
    else if (!run)              step <= '0;
    else if (tick) begin
      if (step == STEP_W'(LAST)) step <= '0;
      else                       step <= step + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (smp_pulse) begin
      code            <= '0;
      code[RES_W-1]   <= 1'b1;
    end else if (bit_step) begin
      code[bidx] <= cmp_in;
      if (bidx > 0) code[bidx-1] <= 1'b1;
    end
  end
endmodule

// File: rtl/aux_avg_acc.sv
module aux_avg_acc #(
  parameter int RES_W = 10,
  parameter int ACC_W = 15,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [RES_W-1:0] din,
  input  logic [SH_W-1:0]  sh,
  output logic [RES_W-1:0] avg_next
);
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] total;

  assign total    = sum + ACC_W'(din);
  assign avg_next = RES_W'(total >> sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= total;
  end
endmodule

// File: rtl/aux_ser_tx.sv
module aux_ser_tx #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] din,
  output logic             ser_out,
  output logic             ser_valid
);
  localparam int LEFT_W = $clog2(RES_W + 1);

  logic [RES_W-1:0]  shreg;
  logic [LEFT_W-1:0] left;

  assign ser_valid = (left != '0);
  assign ser_out   = ser_valid && shreg[RES_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= din;
      left  <= LEFT_W'(RES_W);
    end else if (ser_valid) begin
      shreg <= {shreg[RES_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/aux_sar_seq.sv
module aux_sar_seq #(
  parameter int RES_W        = 10,
  parameter int AVG_LOG2_MAX = 5,
  parameter int AVG_CODE_W   = 3,
  parameter int DIV_CODE_W   = 3,
  parameter int SRC_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [10:0]      ctrl_wdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             hold_smp,
  output logic             ref_sel_o,
  output logic [SRC_W-1:0] src_sel_o,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             ser_out,
  output logic             ser_valid
);
  import aux_sar_pkg::*;

  localparam int ACC_W     = RES_W + AVG_LOG2_MAX;
  localparam int DIV_CNT_W = (1 << DIV_CODE_W) - 1;
  localparam int CNUM_W    = AVG_LOG2_MAX + 1;
  localparam int SH_W      = $clog2(AVG_LOG2_MAX + 1);
  localparam int GO_B      = 0;
  localparam int SRC_LSB   = 1;
  localparam int REF_B     = SRC_LSB + SRC_W;
  localparam int AVG_LSB   = REF_B + 1;
  localparam int DIV_LSB   = AVG_LSB + AVG_CODE_W;
  localparam int SER_B     = DIV_LSB + DIV_CODE_W;

  // named internal events
  logic                 start_acc;
  logic                 conv_tick;
  logic                 conv_load;
  logic                 seq_end;
  logic [RES_W-1:0]     avg_next;

  logic                 go;
  logic [SH_W-1:0]      lat_sh;
  logic [DIV_CNT_W-1:0] lat_lim;
  logic                 lat_ser;
  logic [CNUM_W-1:0]    cnum;
  logic [CNUM_W-1:0]    cnum_last;

  assign start_acc = ctrl_we && ctrl_wdata[GO_B] && !go;
  assign cnum_last = CNUM_W'(conv_last(int'(lat_sh)));
  assign seq_end   = conv_load && (cnum == cnum_last);
  assign busy      = go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go        <= 1'b0;
      lat_sh    <= '0;
      lat_lim   <= '0;
      lat_ser   <= 1'b0;
      ref_sel_o <= 1'b0;
      src_sel_o <= '0;
    end else if (start_acc) begin
      go        <= 1'b1;
      lat_sh    <= SH_W'(avg_log2(ctrl_wdata[AVG_LSB +: AVG_CODE_W], AVG_LOG2_MAX));
      lat_lim   <= DIV_CNT_W'(div_limit(int'(ctrl_wdata[DIV_LSB +: DIV_CODE_W])));
      lat_ser   <= ctrl_wdata[SER_B];
      ref_sel_o <= ctrl_wdata[REF_B];
      src_sel_o <= ctrl_wdata[SRC_LSB +: SRC_W];
    end else if (seq_end) begin
      go <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnum <= '0;
    else if (start_acc) cnum <= '0;
    else if (conv_load) cnum <= cnum + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= seq_end;
      if (seq_end) result <= avg_next;
    end
  end

  aux_ce_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (go),
    .lim  (lat_lim),
    .tick (conv_tick)
  );

  aux_sar_core #(.RES_W(RES_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (go),
    .tick      (conv_tick),
    .cmp_in    (cmp_in),
    .dac_code  (dac_code),
    .smp_pulse (hold_smp),
    .load_pulse(conv_load)
  );

  aux_avg_acc #(.RES_W(RES_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_acc),
    .add     (conv_load),
    .din     (dac_code),
    .sh      (lat_sh),
    .avg_next(avg_next)
  );

  aux_ser_tx #(.RES_W(RES_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seq_end && lat_ser),
    .din      (avg_next),
    .ser_out  (ser_out),
    .ser_valid(ser_valid)
  );
endmodule

// File: rtl/aux_sar_seq_chk.sv
module aux_sar_seq_chk #(
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             seq_end,
  input logic             result_valid,
  input logic             hold_smp,
  input logic             ser_valid,
  input logic             ser_out,
  input logic             ref_sel_o,
  input logic [SRC_W-1:0] src_sel_o
);
  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result_valid);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_end) |=> busy);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ref_sel_o) && $stable(src_sel_o)));

  // R10
  smp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_smp |-> busy);

  // R8
  ser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_out);
endmodule

bind aux_sar_seq aux_sar_seq_chk #(.SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .seq_end     (seq_end),
  .result_valid(result_valid),
  .hold_smp    (hold_smp),
  .ser_valid   (ser_valid),
  .ser_out     (ser_out),
  .ref_sel_o   (ref_sel_o),
  .src_sel_o   (src_sel_o)
);

// File: tb/tb_aux_sar_seq.sv
module tb_aux_sar_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [10:0] ctrl_wdata = '0;
  logic        cmp_in;
  logic [9:0]  dac_code;
  logic        hold_smp, ref_sel_o, busy, result_valid, ser_out, ser_valid;
  logic [1:0]  src_sel_o;
  logic [9:0]  result;

  int n_chk = 0;
  int n_bad = 0;
  int vtab [32];
  int conv_idx = 0;
  int base = 0;
  int vi;

  always #4 clk = ~clk;

  aux_sar_seq dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .hold_smp(hold_smp),
    .ref_sel_o(ref_sel_o), .src_sel_o(src_sel_o), .busy(busy),
    .result(result), .result_valid(result_valid),
    .ser_out(ser_out), .ser_valid(ser_valid)
  );

  // comparator model: a new table entry per sample strobe
  always @(posedge clk) if (hold_smp) conv_idx <= conv_idx + 1;
  always_comb begin
    vi = conv_idx - base - 1;
    if (vi < 0)  vi = 0;
    if (vi > 31) vi = 31;
    cmp_in = (vtab[vi] >= int'(dac_code));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input int avg);
    return 1 << ((avg > 5) ? 5 : avg);
  endfunction

  function automatic int exp_avg(input int avg);
    int s = 0;
    int n = exp_n(avg);
    for (int k = 0; k < n; k++) s += (vtab[k] > 1023) ? 1023 : vtab[k];
    return s / n;
  endfunction

  // mid: 0 none, 1 write start=1 mid-run, 2 write start=0 mid-run
  // fill: 0 random, 1 all zero, 2 all above full scale
  task automatic run_seq(input int avg, input int dv, input int rs, input int ss,
                         input int ser, input int mid, input int fill);
    int cnt = 0, smp = 0, latbad = 0, expv, n, pend = 0, sbad = 0;
    for (int k = 0; k < 32; k++)
      vtab[k] = (fill == 1) ? 0 : (fill == 2) ? 1100 : int'($urandom_range(0, 1100));
    n = exp_n(avg);
    expv = exp_avg(avg);
    base = conv_idx;
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = {ser[0], dv[2:0], avg[2:0], rs[0], ss[1:0], 1'b1};
    @(negedge clk);
    ctrl_we = 1'b0;
    while (busy && cnt < 60000) begin
      cnt++;
      if (pend == 1) begin
        check(dac_code == 10'h200, "R4 first trial code", dac_code, 512);
        pend = 2;
      end
      if (hold_smp && smp == 0) pend = 1;
      if (hold_smp) smp++;
      if (ref_sel_o != rs[0] || src_sel_o != ss[1:0]) latbad++;
      if (cnt == 5 && mid != 0) begin
        ctrl_we = 1'b1;
        ctrl_wdata = {~ser[0], ~dv[2:0], ~avg[2:0], ~rs[0], ~ss[1:0], (mid == 1)};
      end
      if (cnt == 6) ctrl_we = 1'b0;
      @(negedge clk);
    end
    check(cnt == 12 * n * (1 << dv), (mid != 0) ? "R3 length after mid write" : "R2/R6 busy length",
          cnt, 12 * n * (1 << dv));
    check(smp == n, "R10 sample strobes", smp, n);
    check(latbad == 0, "R7 selects held", latbad, 0);
    check(result_valid == 1'b1, "R9 valid pulse", result_valid, 1);
    check(result == expv, "R4/R5 averaged result", result, expv);
    for (int b = 9; b >= 0; b--) begin
      if (ser != 0) begin
        if (!(ser_valid && ser_out == expv[b])) sbad++;
      end else if (ser_valid || ser_out) sbad++;
      @(negedge clk);
      if (b == 9) begin
        check(result_valid == 1'b0, "R9 single cycle", result_valid, 0);
        check(busy == 1'b0, "R3 no restart", busy, 0);
      end
    end
    check(sbad == 0, (ser != 0) ? "R8 serial bits" : "R8 serial idle", sbad, 0);
    check(ser_valid == 1'b0, "R8 serial end", ser_valid, 0);
    check(result == expv, "R9 result held", result, expv);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    for (int k = 0; k < 32; k++) vtab[k] = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && result == 0 && result_valid == 0, "R1 reset outputs", busy, 0);
    check(dac_code == 0 && hold_smp == 0, "R1 reset dac", dac_code, 0);
    check(ref_sel_o == 0 && src_sel_o == 0 && ser_out == 0 && ser_valid == 0,
          "R1 reset selects", src_sel_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 write with start=0 while idle does nothing
    ctrl_we = 1'b1; ctrl_wdata = 11'h7FE;
    @(negedge clk); ctrl_we = 1'b0;
    @(negedge clk);
    check(busy == 0 && src_sel_o == 0, "R1 idle write without start", busy, 0);

    run_seq(0, 0, 1, 2, 1, 0, 0);
    run_seq(0, 0, 0, 3, 0, 0, 1);
    run_seq(0, 0, 1, 1, 1, 0, 2);
    run_seq(7, 0, 0, 1, 1, 0, 0);
    run_seq(6, 1, 1, 0, 0, 0, 0);
    run_seq(0, 7, 1, 3, 1, 0, 0);
    run_seq(5, 1, 0, 2, 1, 1, 0);
    run_seq(2, 2, 1, 1, 0, 2, 0);
    run_seq(0, 0, 0, 0, 1, 1, 2);
    for (int i = 0; i < 22; i++)
      run_seq(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 2)), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule